// File: doc/BRIEF.md
# Idle Retention Entry Delay Controller

This block holds one 32-bit power control word and uses it to decide when a processor core, or its vector/floating-point unit, may drop into a low-leakage retention state after going idle. Three independent domains are timed: core idle entered by wait-for-interrupt, core idle entered by wait-for-event, and the vector/floating-point unit's own idle indication. Each domain owns a 3-bit delay code. Code zero disables that domain. Any other code selects a number of slow timer ticks that must pass while the domain stays idle before a level retention request is raised toward the external power controller.

Delays are measured in strobes of a slow architectural timer tick input, not in core clock cycles. A tick strobe is one core clock wide. With a tick of 10 to 50 MHz, code 001 gives a delay of roughly 40 to 200 ns. Each request stays high for as long as its domain remains idle. It drops, and its count restarts from zero, when idle ends, when a wake event arrives, or when software writes a different code into that domain's field.

A separate power-down request output passes the power-down enable bit through, gated only by wait-for-interrupt idle, with no delay. The register port is a plain one-cycle write strobe with a combinational read. No data streams through this block, so there is no valid/ready handshake and no back-pressure. All idle, wake and tick pins are plain levels or strobes.

Top module: `idle_ret_ctrl`

## Requirements
- R1: Register bits [31:13] and [3:1] always read as zero, and writes to them are ignored.
- R2: After reset the register reads zero. A write takes effect on the clock edge where `cfg_wr_en` is high, and the read port returns the written implemented bits from the next cycle on. The wait-for-interrupt code is at bits [6:4], the wait-for-event code at [9:7], the vector/FP code at [12:10], and the power-down enable at bit 0.
- R3: A domain whose code is 000 never raises its retention request, however many ticks pass while it is idle.
- R4: Codes 001 to 111 require 2, 8, 32, 64, 128, 256 and 512 ticks. The request rises in the cycle that follows the clock edge at which the last required tick is sampled while idle is held, and it is low before then.
- R5: Only clock edges with `tmr_tick` high advance a count. Core clock edges without a tick do not.
- R6: A request drops in the same cycle that its idle input falls or `wake_evt` is high. The count restarts from zero, so a new idle period needs the full tick count again.
- R7: Once raised, a request stays high while its domain stays idle with no wake, however many further ticks arrive. The count saturates and does not wrap.
- R8: A write that changes a domain's code restarts that domain's count under the new code. A write that leaves the code unchanged does not disturb the count.
- R9: The vector/FP domain counts only while `vfp_idle` is high, independently of the two core idle inputs. `wake_evt` clears all three domains.
- R10: `pwrdn_req` equals bit 0 ANDed with `core_wfi_idle`, with no tick delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| core_wfi_idle | input | 1 | Core idle through wait-for-interrupt |
| core_wfe_idle | input | 1 | Core idle through wait-for-event |
| vfp_idle | input | 1 | Vector/FP unit idle |
| wake_evt | input | 1 | Wake event, clears all counts |
| tmr_tick | input | 1 | One-cycle architectural timer tick strobe |
| wfi_ret_req | output | 1 | Retention request for the wait-for-interrupt domain |
| wfe_ret_req | output | 1 | Retention request for the wait-for-event domain |
| vfp_ret_req | output | 1 | Retention request for the vector/FP domain |
| pwrdn_req | output | 1 | Power-down request |

## Verification
The assertions check the following on every cycle:
- Reserved bits read zero and each write lands in the read port one cycle later.
- A count never exceeds its code's threshold, which is the saturation property.
- A count stays put on tick-less edges, and clears one cycle after its domain leaves idle.
- A raised request is held while its domain stays idle.

Only the bench's scenarios can show the exact tick count of each of the seven codes and that code 000 stays silent. They also show that a same-value write leaves a count alone while a changed code restarts it, and that a wake event or a fresh idle period makes the full count necessary again.

// File: rtl/idle_ret_pkg.sv
package idle_ret_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_DOM  = 3;
  localparam int FIELD_W  = 3;
  localparam int FIELD_B0 = 4;
  localparam int CNT_W    = 10;
  localparam int DOM_WFI  = 0;
  localparam int DOM_WFE  = 1;
  localparam int DOM_VFP  = 2;
  localparam int PDN_BIT  = 0;

  function automatic int field_lsb(input int dom);
    return FIELD_B0 + FIELD_W * dom;
  endfunction

  function automatic logic [REG_W-1:0] impl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[PDN_BIT] = 1'b1;
    for (int d = 0; d < NUM_DOM; d++)
      for (int b = 0; b < FIELD_W; b++)
        m[field_lsb(d) + b] = 1'b1;
    return m;
  endfunction

  // Delay code to tick count: 0 disables, 1->2, 2->8, 3->32, 4..7 -> 2^(code+2)
  function automatic logic [CNT_W-1:0] ticks_for(input logic [FIELD_W-1:0] c);
    logic [CNT_W-1:0] r;
    case (c)
      3'd0:    r = '0;
      3'd1:    r = CNT_W'(2);
      3'd2:    r = CNT_W'(8);
      3'd3:    r = CNT_W'(32);
      default: r = CNT_W'(1) << ({1'b0, c} + 4'd2);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ret_ctl_reg.sv
module ret_ctl_reg
  import idle_ret_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en_i,
  input  logic [REG_W-1:0]                  wr_data_i,
  output logic [REG_W-1:0]                  rd_data_o,
  output logic [NUM_DOM-1:0][FIELD_W-1:0]   code_o,
  output logic [NUM_DOM-1:0]                restart_o,
  output logic                              pdn_en_o
);
  localparam logic [REG_W-1:0] MASK = impl_mask();

  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       reg_q <= '0;
    else if (wr_en_i) reg_q <= wr_data_i & MASK;
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_fld
    localparam int LSB = FIELD_B0 + FIELD_W * d;
    assign code_o[d]    = reg_q[LSB +: FIELD_W];
    assign restart_o[d] = wr_en_i && (wr_data_i[LSB +: FIELD_W] != reg_q[LSB +: FIELD_W]);
  end

  assign pdn_en_o  = reg_q[PDN_BIT];
  assign rd_data_o = reg_q;

  // R1: reserved bits read zero
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~MASK) == '0);

  // R2: a write is visible on the read port one cycle later
  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (rd_data_o == ($past(wr_data_i) & MASK)));
endmodule

// File: rtl/ret_timer.sv
module ret_timer
  import idle_ret_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_i,
  input  logic               wake_i,
  input  logic               tick_i,
  input  logic [FIELD_W-1:0] code_i,
  input  logic               restart_i,
  output logic               req_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;
  logic          enabled;
  logic          hold;

  assign thr     = CW'(ticks_for(code_i));
  assign enabled = (code_i != '0);
  assign hold    = idle_i && !wake_i && enabled;

  always_ff @(posedge clk) begin
    if (!rst_n || !hold || restart_i) cnt_q <= '0;
    else if (tick_i && (cnt_q < thr)) cnt_q <= cnt_q + 1'b1;
  end

  assign req_o = hold && (cnt_q >= thr);

  // R7: count never passes its threshold (saturation)
  p_cnt_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= thr);

  // R5: no tick, no advance
  p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && !wake_i && !restart_i && !tick_i) |=> $stable(cnt_q));

  // R6: leaving idle clears the count
  p_exit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> (cnt_q == '0));

  // R7: a raised request is held while idle continues
  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !restart_i) |=> (req_o || !idle_i || wake_i));
endmodule

// File: rtl/idle_ret_ctrl.sv
module idle_ret_ctrl
  import idle_ret_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             core_wfi_idle,
  input  logic             core_wfe_idle,
  input  logic             vfp_idle,
  input  logic             wake_evt,
  input  logic             tmr_tick,
  output logic             wfi_ret_req,
  output logic             wfe_ret_req,
  output logic             vfp_ret_req,
  output logic             pwrdn_req
);
  logic [NUM_DOM-1:0][FIELD_W-1:0] code;
  logic [NUM_DOM-1:0]              restart;
  logic [NUM_DOM-1:0]              idle_vec;
  logic [NUM_DOM-1:0]              req_vec;
  logic                            pdn_en;

  assign idle_vec[DOM_WFI] = core_wfi_idle;
  assign idle_vec[DOM_WFE] = core_wfe_idle;
  assign idle_vec[DOM_VFP] = vfp_idle;

  ret_ctl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cfg_wr_en),
    .wr_data_i (cfg_wr_data),
    .rd_data_o (cfg_rd_data),
    .code_o    (code),
    .restart_o (restart),
    .pdn_en_o  (pdn_en)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    ret_timer #(.CW(CNT_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle_i    (idle_vec[d]),
      .wake_i    (wake_evt),
      .tick_i    (tmr_tick),
      .code_i    (code[d]),
      .restart_i (restart[d]),
      .req_o     (req_vec[d])
    );
  end

  assign wfi_ret_req = req_vec[DOM_WFI];
  assign wfe_ret_req = req_vec[DOM_WFE];
  assign vfp_ret_req = req_vec[DOM_VFP];
  assign pwrdn_req   = pdn_en && core_wfi_idle;

  // R10: power-down request follows WFI idle in the same cycle
  p_pwrdn_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !core_wfi_idle |-> !pwrdn_req);
endmodule

// File: tb/idle_ret_ctrl_tb_top.sv
`timescale 1ns/1ps
module idle_ret_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        core_wfi_idle = 1'b0, core_wfe_idle = 1'b0, vfp_idle = 1'b0;
  logic        wake_evt = 1'b0, tmr_tick = 1'b0;
  logic        wfi_ret_req, wfe_ret_req, vfp_ret_req, pwrdn_req;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  idle_ret_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .core_wfi_idle(core_wfi_idle), .core_wfe_idle(core_wfe_idle),
    .vfp_idle(vfp_idle), .wake_evt(wake_evt), .tmr_tick(tmr_tick),
    .wfi_ret_req(wfi_ret_req), .wfe_ret_req(wfe_ret_req), .vfp_ret_req(vfp_ret_req),
    .pwrdn_req(pwrdn_req)
  );

  // ---------------- reference model ----------------
  int tick_need [8] = '{0, 2, 8, 32, 64, 128, 256, 512};
  int m_reg = 0;
  int m_cnt [3] = '{0, 0, 0};

  function automatic int m_code(input int r, input int d);
    return (r >> (4 + 3 * d)) & 7;
  endfunction

  function automatic bit m_idle(input int d);
    if (d == 0) return core_wfi_idle;
    if (d == 1) return core_wfe_idle;
    return vfp_idle;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 0;
      for (int d = 0; d < 3; d++) m_cnt[d] = 0;
    end else begin
      for (int d = 0; d < 3; d++) begin
        int oc, nc;
        oc = m_code(m_reg, d);
        nc = m_code(int'(cfg_wr_data), d);
        if (!m_idle(d) || wake_evt || oc == 0 || (cfg_wr_en && nc != oc))
          m_cnt[d] = 0;
        else if (tmr_tick && m_cnt[d] < tick_need[oc])
          m_cnt[d] = m_cnt[d] + 1;
      end
      if (cfg_wr_en) m_reg = int'(cfg_wr_data) & 32'h1FF1;
    end
  end

  function automatic bit m_req(input int d);
    int c;
    c = m_code(m_reg, d);
    return m_idle(d) && !wake_evt && c != 0 && m_cnt[d] >= tick_need[c];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1/R2 rd_data", int'(cfg_rd_data), m_reg);
      chk("R4 wfi_ret_req", int'(wfi_ret_req), int'(m_req(0)));
      chk("R4 wfe_ret_req", int'(wfe_ret_req), int'(m_req(1)));
      chk("R9 vfp_ret_req", int'(vfp_ret_req), int'(m_req(2)));
      chk("R10 pwrdn_req", int'(pwrdn_req), int'((m_reg & 1) != 0 && core_wfi_idle));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic look();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    step();
    cfg_wr_en = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tmr_tick = 1'b1;
      step();
      tmr_tick = 1'b0;
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- directed scenarios ----------------
  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    look();
    chk("R2 reset value", int'(cfg_rd_data), 0);

    // R1: reserved bits dropped
    wr(32'hFFFF_FFFF);
    look();
    chk("R1 reserved masked", int'(cfg_rd_data), 32'h1FF1);
    wr(32'h0);

    // R3: code 000 never requests; R10 power-down passthrough
    wr(32'h1);
    core_wfi_idle = 1'b1;
    look();
    chk("R10 pwrdn with wfi idle", int'(pwrdn_req), 1);
    ticks(600, 0);
    look();
    chk("R3 disabled domain silent", int'(wfi_ret_req), 0);
    core_wfi_idle = 1'b0;
    look();
    chk("R10 pwrdn drops with idle", int'(pwrdn_req), 0);

    // R4/R5: WFI code 001 with sparse ticks
    wr(32'h10);
    core_wfi_idle = 1'b1;
    ticks(1, 4);
    look();
    chk("R5 one tick of two", int'(wfi_ret_req), 0);
    ticks(1, 4);
    look();
    chk("R4 wfi code1 at 2 ticks", int'(wfi_ret_req), 1);
    // R7: more ticks, request held
    ticks(20, 1);
    look();
    chk("R7 held after extra ticks", int'(wfi_ret_req), 1);
    // R6: idle exit drops at once, restart from zero
    core_wfi_idle = 1'b0;
    look();
    chk("R6 drop on idle exit", int'(wfi_ret_req), 0);
    step();
    core_wfi_idle = 1'b1;
    ticks(1, 0);
    look();
    chk("R6 count restarted", int'(wfi_ret_req), 0);
    core_wfi_idle = 1'b0;
    step();

    // R4: every code on the WFE domain
    for (int c = 1; c < 8; c++) begin
      wr(32'(c) << 7);
      core_wfe_idle = 1'b1;
      ticks(tick_need[c] - 1, 1);
      look();
      chk($sformatf("R4 code%0d one short", c), int'(wfe_ret_req), 0);
      ticks(1, 0);
      look();
      chk($sformatf("R4 code%0d reached", c), int'(wfe_ret_req), 1);
      core_wfe_idle = 1'b0;
      step();
    end
    wr(32'h0);

    // R8: same-value write keeps count, changed code restarts it
    wr(32'h20);
    core_wfi_idle = 1'b1;
    ticks(5, 0);
    wr(32'h20);
    ticks(3, 0);
    look();
    chk("R8 same write keeps count", int'(wfi_ret_req), 1);
    core_wfi_idle = 1'b0;
    step();
    core_wfi_idle = 1'b1;
    ticks(5, 0);
    wr(32'h30);
    ticks(31, 0);
    look();
    chk("R8 new code restarts", int'(wfi_ret_req), 0);
    ticks(1, 0);
    look();
    chk("R8 new threshold met", int'(wfi_ret_req), 1);
    core_wfi_idle = 1'b0;
    step();

    // R9: vector/FP domain independent; wake clears
    wr(32'h410);
    vfp_idle = 1'b1;
    ticks(2, 0);
    look();
    chk("R9 vfp request", int'(vfp_ret_req), 1);
    chk("R9 wfi untouched", int'(wfi_ret_req), 0);
    wake_evt = 1'b1;
    look();
    chk("R6 wake drops request", int'(vfp_ret_req), 0);
    step();
    wake_evt = 1'b0;
    ticks(1, 0);
    look();
    chk("R6 wake restarted count", int'(vfp_ret_req), 0);
    ticks(1, 0);
    look();
    chk("R9 vfp after wake", int'(vfp_ret_req), 1);
    vfp_idle = 1'b0;
    repeat (4) step();

    finish_run();
  end
endmodule